// File: doc/BRIEF.md
# DRAM Data-Bus Turnaround Enforcer

This block sits between a command source and a DRAM command issue port. It lets read and write column commands through only when the shared data bus will get the idle gap it needs between the end of one burst and the start of the next. It keeps a small set of wait counters, one per rank for reads and one for writes. Every granted command loads these counters with the earliest time the next command of each class may issue. A candidate command is held, with nothing lost, until its counter has drained.

Gaps are set from the data windows. A read's data occupies `BURST` beats starting `RD_LAT` clocks after the command. A write's data starts `WR_LAT` clocks after the command. One idle clock is always kept between bursts that change direction or change the read rank. Three 2-bit settings add 0 to 3 extra idle clocks, one for each case: read then write, write then read, and read then read on a different rank. A write followed by a read to the same rank must also meet a separate write-to-read command delay. The larger of that delay and the turnaround gap applies.

Top module: `bus_turnaround`

## Requirements
- R1: After reset no earlier transfer is assumed, so the first command of any type or rank is granted in the same cycle it is presented.
- R2: `cmdReady` and `issueValid` are high only while `cmdValid` is high and the command's class has no pending wait. A command held for a wait stays presented and is granted in the first allowed cycle. In a grant cycle `issueIsWrite` and `issueRank` equal the presented command. After any grant the wait counters count down by one each clock until a new grant reloads them.
- R3: A read to the same rank as the previous read may issue `BURST` clocks after it, so the data is back to back. That is 4 clocks with default parameters.
- R4: A read to a different rank from the previous read needs `BURST + 1 + cfgRdToRdX` clocks. That is 5 to 8 with defaults, where the 2-bit field counts extra idle clocks.
- R5: A write to any rank after a read needs `RD_LAT + BURST + 1 + cfgRdToWr - WR_LAT` clocks, with a minimum of 1. That is 6 to 9 with defaults.
- R6: A read to a different rank after a write needs `WR_LAT + BURST + 1 + cfgWrToRd - RD_LAT` clocks, with a minimum of 1. That is 4 to 7 with defaults.
- R7: A read to the same rank after a write needs the larger of the R6 gap and `WR_LAT + BURST - 1 + cfgWtr` clocks. The second term counts from the write's last data beat. With defaults it is 7 + `cfgWtr`.
- R8: A write after a write needs `BURST` clocks, with no idle gap, whatever the settings are.
- R9: Each constraint set by an earlier grant stays in force when a later grant would allow an earlier issue. The block applies the latest of all pending limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRdToWr | input | 2 | Extra idle clocks for read followed by write |
| cfgWrToRd | input | 2 | Extra idle clocks for write followed by read |
| cfgRdToRdX | input | 2 | Extra idle clocks for reads on different ranks |
| cfgWtr | input | WTR_W | Same-rank write-to-read delay after the last write beat |
| cmdValid | input | 1 | Candidate command present |
| cmdIsWrite | input | 1 | Candidate is a write (1) or a read (0) |
| cmdRank | input | RANK_W | Candidate target rank |
| cmdReady | output | 1 | Candidate accepted this cycle |
| issueValid | output | 1 | Command issued this cycle |
| issueIsWrite | output | 1 | Type of the issued command |
| issueRank | output | RANK_W | Rank of the issued command |

## Verification
The assertions check on every cycle that a grant never happens without a candidate. They also check that an idle wait counter only counts down. Right after a read grant they check that writes are blocked, and right after a write grant they check that reads to every rank are blocked. Only the bench scenarios can show the exact gap length for each pair of types and ranks under different settings. The same holds for the same-rank write-to-read rule taking over from the turnaround gap, and for an older grant's limit outlasting a newer one.

// File: rtl/ta_pkg.sv
package ta_pkg;

  typedef struct packed {
    logic grant;
    logic isWrite;
  } taStrobe_t;

  function automatic int clampOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ta_datapath.sv
module ta_datapath
  import ta_pkg::*;
#(
  parameter int RD_LAT    = 5,
  parameter int WR_LAT    = 4,
  parameter int BURST     = 4,
  parameter int NUM_RANKS = 2,
  parameter int WTR_W     = 3,
  parameter int RANK_W    = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cfgRdToWr,
  input  logic [1:0]           cfgWrToRd,
  input  logic [1:0]           cfgRdToRdX,
  input  logic [WTR_W-1:0]     cfgWtr,
  input  taStrobe_t            strobe,
  input  logic [RANK_W-1:0]    grantRank,
  output logic [NUM_RANKS-1:0] rdClear,
  output logic                 wrClear
);

  localparam int MAX_DELAY  = RD_LAT + WR_LAT + BURST + (1 << WTR_W) + 8;
  localparam int CNT_W      = $clog2(MAX_DELAY + 1);
  localparam int RD_WR_BASE = RD_LAT + BURST + 1 - WR_LAT;
  localparam int WR_RD_BASE = WR_LAT + BURST + 1 - RD_LAT;
  localparam int WR_RD_MIN  = clampOne(WR_RD_BASE) - 1;
  localparam int RD_WR_MIN  = clampOne(RD_WR_BASE) - 1;

  // Reload values are the gap minus one: the counter reads that value in the
  // cycle after the grant and reaches zero in the first allowed cycle.
  logic [CNT_W-1:0] nRdSame, nRdOther, nRdWr, nWrWr, nWrRdOther, nWrRdSame;

  always_comb begin
    int wrRdTurn;
    int wtrGap;
    wrRdTurn   = clampOne(WR_RD_BASE + int'(cfgWrToRd)) - 1;
    wtrGap     = clampOne(WR_LAT + BURST - 1 + int'(cfgWtr)) - 1;
    nRdSame    = CNT_W'(BURST - 1);
    nRdOther   = CNT_W'(BURST + int'(cfgRdToRdX));
    nRdWr      = CNT_W'(clampOne(RD_WR_BASE + int'(cfgRdToWr)) - 1);
    nWrWr      = CNT_W'(BURST - 1);
    nWrRdOther = CNT_W'(wrRdTurn);
    nWrRdSame  = CNT_W'(maxInt(wrRdTurn, wtrGap));
  end

  logic [CNT_W-1:0] rdWait [NUM_RANKS];
  logic [CNT_W-1:0] wrWait;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [CNT_W-1:0] decd, need, nxt;
    logic             sameRank;

    always_comb begin
      sameRank = (RANK_W'(r) == grantRank);
      decd     = (rdWait[r] == '0) ? '0 : rdWait[r] - 1'b1;
      if (strobe.isWrite) need = sameRank ? nWrRdSame : nWrRdOther;
      else                need = sameRank ? nRdSame   : nRdOther;
      nxt = (strobe.grant && (need > decd)) ? need : decd;
    end

    always_ff @(posedge clk) begin
      if (!rstN) rdWait[r] <= '0;
      else       rdWait[r] <= nxt;
    end

    assign rdClear[r] = (rdWait[r] == '0);

    if (WR_RD_MIN > 0) begin : g_chk
      a_r6_write_blocks_reads: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.grant && strobe.isWrite) |=> !rdClear[r]);
    end
  end

  logic [CNT_W-1:0] wrDecd, wrNeed, wrNext;

  always_comb begin
    wrDecd = (wrWait == '0) ? '0 : wrWait - 1'b1;
    wrNeed = strobe.isWrite ? nWrWr : nRdWr;
    wrNext = (strobe.grant && (wrNeed > wrDecd)) ? wrNeed : wrDecd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrWait <= '0;
    else       wrWait <= wrNext;
  end

  assign wrClear = (wrWait == '0);

  a_r2_wrwait_counts_down: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.grant && wrWait != '0) |=> (wrWait == $past(wrWait) - 1'b1));

  if (RD_WR_MIN > 0) begin : g_rdwr_chk
    a_r5_read_blocks_writes: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.grant && !strobe.isWrite) |=> !wrClear);
  end

endmodule

// File: rtl/ta_control.sv
module ta_control
  import ta_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int RANK_W    = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdIsWrite,
  input  logic [RANK_W-1:0]    cmdRank,
  input  logic [NUM_RANKS-1:0] rdClear,
  input  logic                 wrClear,
  output taStrobe_t            strobe,
  output logic                 cmdReady,
  output logic                 issueValid,
  output logic                 issueIsWrite,
  output logic [RANK_W-1:0]    issueRank
);

  logic rankOk, classClear;

  always_comb begin
    rankOk     = (int'(cmdRank) < NUM_RANKS);
    classClear = 1'b0;
    if (cmdIsWrite) classClear = wrClear;
    else if (rankOk) classClear = rdClear[cmdRank];
    cmdReady       = cmdValid && rankOk && classClear;
    strobe.grant   = cmdReady;
    strobe.isWrite = cmdIsWrite;
  end

  assign issueValid   = cmdReady;
  assign issueIsWrite = cmdIsWrite;
  assign issueRank    = cmdRank;

  a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> cmdValid);

endmodule

// File: rtl/bus_turnaround.sv
module bus_turnaround
  import ta_pkg::*;
#(
  parameter int RD_LAT    = 5,
  parameter int WR_LAT    = 4,
  parameter int BURST     = 4,
  parameter int NUM_RANKS = 2,
  parameter int WTR_W     = 3,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgRdToWr,
  input  logic [1:0]        cfgWrToRd,
  input  logic [1:0]        cfgRdToRdX,
  input  logic [WTR_W-1:0]  cfgWtr,
  input  logic              cmdValid,
  input  logic              cmdIsWrite,
  input  logic [RANK_W-1:0] cmdRank,
  output logic              cmdReady,
  output logic              issueValid,
  output logic              issueIsWrite,
  output logic [RANK_W-1:0] issueRank
);

  taStrobe_t            strobe;
  logic [NUM_RANKS-1:0] rdClear;
  logic                 wrClear;

  ta_control #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite), .cmdRank(cmdRank),
    .rdClear(rdClear), .wrClear(wrClear),
    .strobe(strobe), .cmdReady(cmdReady),
    .issueValid(issueValid), .issueIsWrite(issueIsWrite), .issueRank(issueRank)
  );

  ta_datapath #(
    .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .BURST(BURST),
    .NUM_RANKS(NUM_RANKS), .WTR_W(WTR_W), .RANK_W(RANK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgRdToWr(cfgRdToWr), .cfgWrToRd(cfgWrToRd), .cfgRdToRdX(cfgRdToRdX),
    .cfgWtr(cfgWtr), .strobe(strobe), .grantRank(cmdRank),
    .rdClear(rdClear), .wrClear(wrClear)
  );

endmodule

// File: tb/bus_turnaround_tb.sv
`timescale 1ns/1ps
module bus_turnaround_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgRdToWr = '0, cfgWrToRd = '0, cfgRdToRdX = '0;
  logic [2:0] cfgWtr = '0;
  logic       cmdValid = 1'b0, cmdIsWrite = 1'b0;
  logic [0:0] cmdRank = '0;
  logic       cmdReady, issueValid, issueIsWrite;
  logic [0:0] issueRank;

  int  nChecks = 0, nFail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  bus_turnaround u_dut (
    .clk(clk), .rstN(rstN),
    .cfgRdToWr(cfgRdToWr), .cfgWrToRd(cfgWrToRd), .cfgRdToRdX(cfgRdToRdX),
    .cfgWtr(cfgWtr), .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite),
    .cmdRank(cmdRank), .cmdReady(cmdReady), .issueValid(issueValid),
    .issueIsWrite(issueIsWrite), .issueRank(issueRank)
  );

  typedef struct packed {
    logic [1:0] rw, wr, rr;
    logic [2:0] wtr;
    logic       w1, r1, w2, r2;
    int         expGap;
    int         req;
  } vec_t;

  // Expected gaps for RD_LAT=5, WR_LAT=4, BURST=4
  localparam vec_t VECS [12] = '{
    '{2'd0, 2'd0, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4, 3}, // R3 same-rank reads
    '{2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5, 4}, // R4
    '{2'd0, 2'd0, 2'd3, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8, 4}, // R4
    '{2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6, 5}, // R5
    '{2'd2, 2'd0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8, 5}, // R5
    '{2'd3, 2'd0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 9, 5}, // R5
    '{2'd0, 2'd1, 2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5, 6}, // R6
    '{2'd0, 2'd3, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 7, 6}, // R6
    '{2'd0, 2'd3, 2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 7, 7}, // R7
    '{2'd0, 2'd0, 2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 9, 7}, // R7
    '{2'd0, 2'd0, 2'd0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8, 7}, // R7
    '{2'd3, 2'd3, 2'd3, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 4, 8}  // R8
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    cmdValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Present a command at the current negedge and count cycles until granted.
  // The grant edge is then consumed and the command is withdrawn.
  task automatic waitGrant(input bit w, input bit r, output int cyc);
    cyc = 0;
    cmdValid = 1'b1; cmdIsWrite = w; cmdRank = r;
    forever begin
      #1;
      if (cmdReady) break;
      if (issueValid) check(0, "R2 issue without ready", 1, 0);
      cyc++;
      if (cyc > 40) break;
      @(negedge clk);
    end
    if (cmdReady) begin
      check(issueIsWrite == w && issueRank == r, "R2 issued fields",
            {issueIsWrite, issueRank}, {w, r});
      @(negedge clk);
    end
    cmdValid = 1'b0;
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(cmdReady == 0 && issueValid == 0, "R2 idle after reset", cmdReady, 0);

    // R1: first command granted at once, any type and rank
    waitGrant(1'b1, 1'b1, g);
    check(g == 0, "R1 first command immediate", g, 0);

    for (int i = 0; i < 12; i++) begin
      idle(30);
      cfgRdToWr = VECS[i].rw; cfgWrToRd = VECS[i].wr;
      cfgRdToRdX = VECS[i].rr; cfgWtr = VECS[i].wtr;
      waitGrant(VECS[i].w1, VECS[i].r1, g);
      check(g == 0, "R2 first of pair after idle", g, 0);
      waitGrant(VECS[i].w2, VECS[i].r2, g);
      // gap counted from the first grant: held cycles + 1
      check(g + 1 == VECS[i].expGap, $sformatf("R%0d gap vector %0d", VECS[i].req, i),
            g + 1, VECS[i].expGap);
    end

    // R9: older same-rank write limit outlasts a newer write on the other rank
    idle(30);
    cfgRdToWr = 0; cfgWrToRd = 0; cfgRdToRdX = 0; cfgWtr = 3'd3;
    waitGrant(1'b1, 1'b0, g);
    waitGrant(1'b1, 1'b1, g);
    check(g + 1 == 4, "R8 write after write", g + 1, 4);
    waitGrant(1'b0, 1'b0, g);
    check(g + 1 == 6, "R9 older limit kept", g + 1, 6);

    // R2: no grant while valid is low, even with all waits drained
    idle(30);
    cmdIsWrite = 1'b1;
    #1;
    check(cmdReady == 0 && issueValid == 0, "R2 ready needs valid", cmdReady, 0);

    // R1: reset clears pending waits
    waitGrant(1'b0, 1'b0, g);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    waitGrant(1'b1, 1'b1, g);
    check(g == 0, "R1 write right after reset", g, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule